// File: doc/BRIEF.md
# Ethernet MAC statistics counter bank

This block keeps eleven event counters for a 10/100 Ethernet MAC. The transmit and receive engines report each finished frame on a one-cycle completion strobe. Outcome flags and, for transmit, the number of collisions the frame met travel with the strobe. A separate transmit underrun strobe reports each DMA underrun event, and it can fire several times for one frame when the MAC retransmits after an underrun. Every counter saturates at all ones and does not wrap.

Software reads the counters through a command input. A plain dump captures all counters in the cycle the command is accepted. A dump-and-reset captures them in the same way and zeroes the live counters in that same cycle. The captured words then go out one per handshake on a valid/ready write-out port, each tagged with its word index, which is the byte offset divided by four. A one-cycle done pulse follows the last word. An event that arrives in the capture cycle of a dump-and-reset is counted into the new period, so no event is lost.

Top module: `macstat_bank`

## Requirements
- R1: A dump emits eleven words with indices 0 to 10 in this fixed order: 0 tx good, 1 tx aborted at the collision limit, 2 tx late collision, 3 tx underrun, 4 tx carrier lost, 5 tx deferred, 6 tx one collision, 7 tx several collisions, 8 tx collision total, 9 rx good, 10 rx CRC error. Word 0 is presented in the cycle after the command is accepted.
- R2: The tx good counter adds 1 only on a cycle with `tx_done` and `tx_ok` both high. Flags presented without `tx_done` or `rx_done` change no counter.
- R3: On `tx_done` with `tx_ok`, a `tx_coll_cnt` of exactly 1 adds 1 to the one-collision counter, and a value of 2 or more adds 1 to the several-collisions counter. Frames with `tx_ok` low touch neither counter.
- R4: Every `tx_done` adds the full `tx_coll_cnt` value to the collision total, whether the frame was sent, aborted at the limit or hit a late collision.
- R5: On `tx_done`, `tx_maxcol`, `tx_latecol` and `tx_deferred` each add 1 to their own counter. `tx_crs_lost` adds 1 only when `tx_ok` is also high.
- R6: Each cycle with `tx_underrun` high adds 1 to the underrun counter, independent of `tx_done`, so one frame can add several counts.
- R7: On `rx_done`, `rx_ok` adds 1 to rx good. `rx_crc_err` adds 1 to the rx CRC counter only when both `rx_align_err` and `rx_short` are low.
- R8: A counter that would pass 2^CNT_W-1 holds at 2^CNT_W-1.
- R9: A plain dump returns the counter values from before the accepting edge and leaves the live counters running.
- R10: A dump-and-reset returns the values from before the accepting edge. After that edge each counter holds only the events of the accepting cycle.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_index` and `wr_data` hold steady. Each accepted word advances the index by one.
- R12: `dump_done` is high for exactly the one cycle after the word with index 10 is accepted. `cmd_ready` is low while a dump is in progress, and a command issued then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done | input | 1 | Transmit frame finished (one cycle) |
| tx_ok | input | 1 | Frame went out on the link |
| tx_maxcol | input | 1 | Frame aborted at the collision limit |
| tx_latecol | input | 1 | Frame met a late collision |
| tx_crs_lost | input | 1 | Carrier sense dropped during transmission |
| tx_deferred | input | 1 | Frame waited for a busy link |
| tx_coll_cnt | input | COLL_W | Collisions seen by this frame |
| tx_underrun | input | 1 | One DMA underrun event |
| rx_done | input | 1 | Receive frame finished (one cycle) |
| rx_ok | input | 1 | Frame received and all bytes stored |
| rx_crc_err | input | 1 | Frame discarded for a bad CRC |
| rx_align_err | input | 1 | Frame classed as an alignment error |
| rx_short | input | 1 | Frame classed as too short |
| cmd_valid | input | 1 | Dump command request |
| cmd_clear | input | 1 | 1 = dump and reset, 0 = plain dump |
| cmd_ready | output | 1 | Block idle, command accepted |
| wr_valid | output | 1 | Dump word available |
| wr_ready | input | 1 | Consumer takes the word |
| wr_index | output | 4 | Word index (byte offset / 4) |
| wr_data | output | CNT_W | Counter value |
| dump_done | output | 1 | One-cycle end-of-dump pulse |

## Verification
Counter events take effect at the edge that samples their strobe, so a dump accepted at any later edge must include them. A dump-and-reset accepted at that same edge must not. Word 0 is due one cycle after the command is accepted, each later word one cycle after the previous handshake, and `dump_done` one cycle after the handshake on word 10. The bench drives every input on the falling edge and samples outputs on the next falling edge, which puts each check exactly one register stage after its stimulus. Stall cycles are inserted so that the hold behaviour is sampled across a full cycle with `wr_ready` low.

// File: rtl/macstat_pkg.sv
// Shared constants and types for the MAC statistics counter bank.
// Assumes the word order below is fixed; the memory image depends on it.
package macstat_pkg;
    localparam int NUM_CNT = 11;
    localparam int IDX_W   = 4;

    // Word position of each counter in the dump (byte offset = 4 * index)
    typedef enum logic [IDX_W-1:0] {
        IX_TX_GOOD     = 4'd0,
        IX_TX_MAXCOL   = 4'd1,
        IX_TX_LATE     = 4'd2,
        IX_TX_UNDERRUN = 4'd3,
        IX_TX_NOCRS    = 4'd4,
        IX_TX_DEFER    = 4'd5,
        IX_TX_ONECOL   = 4'd6,
        IX_TX_MULTICOL = 4'd7,
        IX_TX_ALLCOL   = 4'd8,
        IX_RX_GOOD     = 4'd9,
        IX_RX_CRC      = 4'd10
    } cnt_idx_e;

    typedef enum logic {
        DS_IDLE = 1'b0,
        DS_SEND = 1'b1
    } dump_state_e;
endpackage

// File: rtl/macstat_event_decode.sv
// Turns per-frame completion strobes into an increment amount per counter.
// Assumes strobes are one cycle wide; the underrun strobe is independent of tx_done.
module macstat_event_decode
    import macstat_pkg::*;
#(
    parameter int COLL_W = 5
) (
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_maxcol,
    input  logic              tx_latecol,
    input  logic              tx_crs_lost,
    input  logic              tx_deferred,
    input  logic [COLL_W-1:0] tx_coll_cnt,
    input  logic              tx_underrun,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              rx_crc_err,
    input  logic              rx_align_err,
    input  logic              rx_short,
    output logic [NUM_CNT-1:0][COLL_W-1:0] inc_amt
);
    logic one_coll;
    logic many_coll;

    // Classify the collision count of a transmitted frame
    always_comb begin
        one_coll  = (tx_coll_cnt == COLL_W'(1));
        many_coll = (tx_coll_cnt >  COLL_W'(1));
    end

    // Per-counter increment, only on completion except for underrun events
    always_comb begin
        inc_amt = '0;
        if (tx_done) begin
            inc_amt[IX_TX_GOOD]     = COLL_W'(tx_ok);
            inc_amt[IX_TX_MAXCOL]   = COLL_W'(tx_maxcol);
            inc_amt[IX_TX_LATE]     = COLL_W'(tx_latecol);
            inc_amt[IX_TX_NOCRS]    = COLL_W'(tx_ok && tx_crs_lost);
            inc_amt[IX_TX_DEFER]    = COLL_W'(tx_deferred);
            inc_amt[IX_TX_ONECOL]   = COLL_W'(tx_ok && one_coll);
            inc_amt[IX_TX_MULTICOL] = COLL_W'(tx_ok && many_coll);
            inc_amt[IX_TX_ALLCOL]   = tx_coll_cnt;
        end
        inc_amt[IX_TX_UNDERRUN] = COLL_W'(tx_underrun);
        if (rx_done) begin
            inc_amt[IX_RX_GOOD] = COLL_W'(rx_ok);
            inc_amt[IX_RX_CRC]  = COLL_W'(rx_crc_err && !rx_align_err && !rx_short);
        end
    end
endmodule

// File: rtl/macstat_counter.sv
// One saturating event counter with a synchronous clear that keeps same-cycle events.
// Assumes INC_W < CNT_W + 1 so the increment fits the sum.
module macstat_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] next_val;

    // Start from zero on a clear, then add and clamp at all ones
    always_comb begin
        base     = clear ? '0 : count;
        sum      = {1'b0, base} + {{(SUM_W-INC_W){1'b0}}, inc};
        next_val = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= next_val;
        end
    end
endmodule

// File: rtl/macstat_dump_seq.sv
// Captures all counters on command acceptance and streams them with valid/ready.
// Assumes the consumer may stall any word; the capture is held until the last word.
module macstat_dump_seq
    import macstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] live_cnt,
    input  logic                          cmd_valid,
    input  logic                          cmd_clear,
    output logic                          cmd_ready,
    output logic                          clear_now,
    output logic                          wr_valid,
    input  logic                          wr_ready,
    output logic [IDX_W-1:0]              wr_index,
    output logic [CNT_W-1:0]              wr_data,
    output logic                          dump_done
);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NUM_CNT - 1);

    dump_state_e                   state;
    logic [NUM_CNT-1:0][CNT_W-1:0] snap;
    logic [IDX_W-1:0]              idx;
    logic                          accept;
    logic                          word_taken;

    // Handshake decode
    always_comb begin
        cmd_ready  = (state == DS_IDLE);
        accept     = cmd_valid && cmd_ready;
        clear_now  = accept && cmd_clear;
        wr_valid   = (state == DS_SEND);
        word_taken = wr_valid && wr_ready;
        wr_index   = idx;
        wr_data    = snap[idx];
    end

    // Sequencer state, word index and end pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= DS_IDLE;
            idx       <= '0;
            dump_done <= 1'b0;
        end else begin
            dump_done <= 1'b0;
            if (accept) begin
                state <= DS_SEND;
                idx   <= '0;
            end else if (word_taken) begin
                if (idx == LAST_IX) begin
                    state     <= DS_IDLE;
                    dump_done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Capture of all counters in the accepting cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (accept) begin
            snap <= live_cnt;
        end
    end
endmodule

// File: rtl/macstat_bank.sv
// Top of the MAC statistics counter bank: decode, eleven counters, dump sequencer.
// Assumes all inputs are synchronous to clk; reset is synchronous active low.
module macstat_bank
    import macstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int COLL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_maxcol,
    input  logic              tx_latecol,
    input  logic              tx_crs_lost,
    input  logic              tx_deferred,
    input  logic [COLL_W-1:0] tx_coll_cnt,
    input  logic              tx_underrun,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              rx_crc_err,
    input  logic              rx_align_err,
    input  logic              rx_short,
    input  logic              cmd_valid,
    input  logic              cmd_clear,
    output logic              cmd_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [3:0]        wr_index,
    output logic [CNT_W-1:0]  wr_data,
    output logic              dump_done
);
    logic [NUM_CNT-1:0][COLL_W-1:0] inc_amt;
    logic [NUM_CNT-1:0][CNT_W-1:0]  live_cnt;
    logic                           clear_now;

    macstat_event_decode #(.COLL_W(COLL_W)) u_decode (
        .tx_done      (tx_done),
        .tx_ok        (tx_ok),
        .tx_maxcol    (tx_maxcol),
        .tx_latecol   (tx_latecol),
        .tx_crs_lost  (tx_crs_lost),
        .tx_deferred  (tx_deferred),
        .tx_coll_cnt  (tx_coll_cnt),
        .tx_underrun  (tx_underrun),
        .rx_done      (rx_done),
        .rx_ok        (rx_ok),
        .rx_crc_err   (rx_crc_err),
        .rx_align_err (rx_align_err),
        .rx_short     (rx_short),
        .inc_amt      (inc_amt)
    );

    // One saturating counter per dump word
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        macstat_counter #(.CNT_W(CNT_W), .INC_W(COLL_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear_now),
            .inc   (inc_amt[g]),
            .count (live_cnt[g])
        );
    end

    macstat_dump_seq #(.CNT_W(CNT_W)) u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_cnt  (live_cnt),
        .cmd_valid (cmd_valid),
        .cmd_clear (cmd_clear),
        .cmd_ready (cmd_ready),
        .clear_now (clear_now),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_index  (wr_index),
        .wr_data   (wr_data),
        .dump_done (dump_done)
    );
endmodule

// File: rtl/macstat_checker.sv
// Protocol checks on the dump port of macstat_bank, attached with bind.
// Assumes it sees only the top-level ports.
module macstat_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [3:0]       wr_index,
    input logic [CNT_W-1:0] wr_data,
    input logic             dump_done
);
    localparam logic [3:0] LAST_IX = 4'd10;

    assert_first_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> wr_valid && (wr_index == 4'd0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_index) && $stable(wr_data));

    assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_index != LAST_IX) |=> wr_valid && (wr_index == $past(wr_index) + 4'd1));

    assert_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_index <= LAST_IX));

    assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_index == LAST_IX) |=> dump_done && !wr_valid);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |=> !dump_done);

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cmd_ready);
endmodule

bind macstat_bank macstat_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_index  (wr_index),
    .wr_data   (wr_data),
    .dump_done (dump_done)
);

// File: tb/macstat_bank_tb.sv
// Self-checking bench: sweeps frame outcomes on an 8-bit configuration and checks dumps.
module macstat_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 8;
    localparam int KW   = 5;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_done = 0, tx_ok = 0, tx_maxcol = 0, tx_latecol = 0, tx_crs_lost = 0, tx_deferred = 0;
    logic [KW-1:0] tx_coll_cnt = '0;
    logic tx_underrun = 0;
    logic rx_done = 0, rx_ok = 0, rx_crc_err = 0, rx_align_err = 0, rx_short = 0;
    logic cmd_valid = 0, cmd_clear = 0, wr_ready = 0;
    logic cmd_ready, wr_valid, dump_done;
    logic [3:0] wr_index;
    logic [CW-1:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    int expv [11];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    macstat_bank #(.CNT_W(CW), .COLL_W(KW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_done(tx_done), .tx_ok(tx_ok), .tx_maxcol(tx_maxcol), .tx_latecol(tx_latecol),
        .tx_crs_lost(tx_crs_lost), .tx_deferred(tx_deferred), .tx_coll_cnt(tx_coll_cnt),
        .tx_underrun(tx_underrun),
        .rx_done(rx_done), .rx_ok(rx_ok), .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
        .rx_short(rx_short),
        .cmd_valid(cmd_valid), .cmd_clear(cmd_clear), .cmd_ready(cmd_ready),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_index(wr_index), .wr_data(wr_data),
        .dump_done(dump_done)
    );

    function automatic int sat(input int a, input int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_tx(input bit ok, input bit mc, input bit lc, input bit crs,
                            input bit df, input int coll);
        expv[0] = sat(expv[0], int'(ok));
        expv[1] = sat(expv[1], int'(mc));
        expv[2] = sat(expv[2], int'(lc));
        expv[4] = sat(expv[4], int'(ok && crs));
        expv[5] = sat(expv[5], int'(df));
        expv[6] = sat(expv[6], int'(ok && coll == 1));
        expv[7] = sat(expv[7], int'(ok && coll > 1));
        expv[8] = sat(expv[8], coll);
    endtask

    // One transmit completion, optionally with an underrun in the same cycle
    task automatic tx_frame(input bit ok, input bit mc, input bit lc, input bit crs,
                            input bit df, input int coll, input bit und);
        @(negedge clk);
        tx_done = 1; tx_ok = ok; tx_maxcol = mc; tx_latecol = lc; tx_crs_lost = crs;
        tx_deferred = df; tx_coll_cnt = KW'(coll); tx_underrun = und;
        model_tx(ok, mc, lc, crs, df, coll);
        if (und) expv[3] = sat(expv[3], 1);
        @(negedge clk);
        tx_done = 0; tx_ok = 0; tx_maxcol = 0; tx_latecol = 0; tx_crs_lost = 0;
        tx_deferred = 0; tx_coll_cnt = '0; tx_underrun = 0;
    endtask

    task automatic rx_frame(input bit done, input bit ok, input bit crc, input bit al, input bit sh);
        @(negedge clk);
        rx_done = done; rx_ok = ok; rx_crc_err = crc; rx_align_err = al; rx_short = sh;
        if (done) begin
            expv[9]  = sat(expv[9], int'(ok));
            expv[10] = sat(expv[10], int'(crc && !al && !sh));
        end
        @(negedge clk);
        rx_done = 0; rx_ok = 0; rx_crc_err = 0; rx_align_err = 0; rx_short = 0;
    endtask

    // Issue a dump; optional clear, same-cycle tx event, stalls and a poke while busy
    task automatic run_dump(input bit clr, input bit with_ev, input bit stall, input bit poke,
                            input string req);
        int snap [11];
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R12 idle ready", int'(cmd_ready), 1);
        cmd_valid = 1; cmd_clear = clr;
        if (with_ev) begin tx_done = 1; tx_ok = 1; tx_coll_cnt = '0; end
        for (int i = 0; i < 11; i++) snap[i] = expv[i];
        if (clr) for (int i = 0; i < 11; i++) expv[i] = 0;
        if (with_ev) model_tx(1, 0, 0, 0, 0, 0);
        @(negedge clk);
        cmd_valid = 0; cmd_clear = 0; tx_done = 0; tx_ok = 0;
        for (int k = 0; k < 11; k++) begin
            chk(wr_valid && wr_index == 4'(k), "R1 word index", int'(wr_index), k);
            chk(int'(wr_data) == snap[k], req, int'(wr_data), snap[k]);
            if (stall && (k % 3 == 1)) begin
                wr_ready = 0;
                if (poke) begin cmd_valid = 1; cmd_clear = 1; end
                chk(cmd_ready == 1'b0, "R12 busy not ready", int'(cmd_ready), 0);
                @(negedge clk);
                cmd_valid = 0; cmd_clear = 0;
                chk(wr_valid && wr_index == 4'(k) && int'(wr_data) == snap[k],
                    "R11 hold under stall", int'(wr_data), snap[k]);
            end
            wr_ready = 1;
            @(negedge clk);
        end
        wr_ready = 0;
        chk(dump_done && !wr_valid, "R12 done after last word", int'(dump_done), 1);
        @(negedge clk);
        chk(!dump_done, "R12 done one cycle", int'(dump_done), 0);
    endtask

    initial begin
        for (int i = 0; i < 11; i++) expv[i] = 0;
        repeat (3) @(negedge clk);
        chk(cmd_ready && !wr_valid && !dump_done, "reset state", int'(wr_valid), 0);
        rst_n = 1;
        run_dump(0, 0, 0, 0, "R1 zero after reset");

        // R2: flags without completion strobes are ignored
        @(negedge clk);
        tx_ok = 1; tx_maxcol = 1; tx_latecol = 1; tx_deferred = 1; tx_coll_cnt = 5'd3;
        rx_ok = 1; rx_crc_err = 1;
        @(negedge clk);
        tx_ok = 0; tx_maxcol = 0; tx_latecol = 0; tx_deferred = 0; tx_coll_cnt = '0;
        rx_ok = 0; rx_crc_err = 0;
        run_dump(0, 0, 0, 0, "R2 no count without done");

        // R3 R4 R5: sweep of outcome flags and small collision counts (no saturation yet)
        for (int m = 0; m < 32; m++)
            for (int c = 0; c < 3; c++)
                tx_frame(m[0], m[1], m[2], m[3], m[4], c, 0);
        run_dump(0, 0, 1, 0, "R3 R4 R5 tx sweep");

        // R7: receive flag sweep, with and without rx_done
        for (int m = 0; m < 32; m++) rx_frame(m[4], m[0], m[1], m[2], m[3]);
        run_dump(0, 0, 0, 0, "R7 rx sweep");

        // R6: several underrun events for one frame
        for (int u = 0; u < 3; u++) begin
            @(negedge clk); tx_underrun = 1; expv[3] = sat(expv[3], 1);
            @(negedge clk); tx_underrun = 0;
        end
        tx_frame(1, 0, 0, 0, 0, 0, 1);
        run_dump(0, 0, 0, 0, "R6 underrun per event");

        // R9 R12: plain dump with a clear poke while busy; counters must survive
        run_dump(0, 0, 1, 1, "R9 plain dump keeps counters");
        run_dump(0, 0, 0, 0, "R12 busy command ignored");

        // R10: dump-and-reset with a same-cycle good frame
        run_dump(1, 1, 1, 0, "R10 capture before clear");
        run_dump(0, 0, 0, 0, "R10 only same-cycle event remains");

        // R8: saturation on underrun and collision total
        for (int u = 0; u < 270; u++) tx_frame(0, 1, 0, 0, 0, 31, 1);
        run_dump(0, 0, 0, 0, "R8 saturate at all ones");
        chk(expv[3] == MAXV && expv[8] == MAXV, "R8 model saturated", expv[3], MAXV);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule